// File: doc/BRIEF.md
# SDRAM Bank Window Decoder

This block maps a physical address onto one of several SDRAM bank windows. Each bank is described by a 32-bit configuration word that a neighbouring register block supplies. The word gives an 8 MiB-aligned base, a three-bit power-of-two size code and a per-bank enable. A global controller enable gates every window at once. For every address presented, the block returns a one-hot hit vector, the index of the winning bank, the byte offset from that bank's base, and a miss flag.

Addresses arrive on a valid/ready stream and results leave on another. When the output register stage is enabled (`REG_OUT=1`), an address is taken when `in_valid` and `in_ready` are both high, and its result appears on the following cycle. A result that `out_ready` does not take stays on the outputs unchanged. `in_ready` is high whenever the output slot is empty or is being emptied in the same cycle. With `REG_OUT=0`, the path is combinational: `out_valid` follows `in_valid` and `in_ready` follows `out_ready`. The configuration words and the global enable are sampled together with the address, so a change to them applies to the next address that is taken.

Top module: `sdwin_decoder`

## Requirements
- R1: The bank base is bits 31:23 of the configuration word followed by 23 zero bits. An address below a bank's base never hits that bank.
- R2: The size code is bits 19:17, and the window covers 4 MiB shifted left by the code. The address base+size-1 hits, and base+size does not hit, including a window that ends at the top of the 32-bit space.
- R3: A bank whose size code is 7 never hits.
- R4: A bank hits only when its bit 0 is 1 and `ctrl_en` is 1. When `ctrl_en` is 0, every address returns a miss.
- R5: When windows overlap, the lowest-numbered matching bank wins, and `out_hit` has only that bank's bit set.
- R6: On a hit, `out_idx` is the bank number, `out_hit` bit i marks bank i, and `out_offset` equals the address minus the base. On a miss, `out_hit`, `out_idx` and `out_offset` are 0.
- R7: Whenever `out_valid` is high, `out_hit` has at most one bit set, and `out_miss` is 1 exactly when `out_hit` is zero.
- R8: With `REG_OUT=1`, an address that is taken produces its result on the next cycle. A result that is not taken holds stable. `in_ready` = !`out_valid` || `out_ready`.
- R9: While `rst_n` is low, and on the first cycle after it, `out_valid` is 0.
- R10: The configuration words and `ctrl_en` are sampled when the address is taken. A later change does not alter a result that is already waiting on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_en | input | 1 | Global controller enable |
| bank_cfg | input | NUM_BANKS*32 | Bank configuration words, bank i at bits [32*i+31:32*i] |
| in_valid | input | 1 | Address valid |
| in_ready | output | 1 | Address accepted when high together with in_valid |
| in_addr | input | 32 | Physical address to decode |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high together with out_valid |
| out_hit | output | NUM_BANKS | One-hot winning bank |
| out_idx | output | clog2(NUM_BANKS) | Winning bank number |
| out_offset | output | 32 | Address minus the winning bank's base |
| out_miss | output | 1 | No bank claimed the address |

## Verification
The assertions check several properties on every cycle. They check that the hit vector is one-hot-or-zero and agrees with the miss flag. They check that the index points at the set hit bit, and that a miss clears the index and offset. They also check that a result held by back-pressure stays stable, and that an address taken with the global enable low comes out as a miss. Only the bench's scenarios can show that the window arithmetic is right. These cover the exact base and end addresses of each size, a window that ends at the top of the address space, the rejection of size code 7, overlap priority, and the sampling of `ctrl_en` at acceptance rather than at output. In these scenarios, a reference model computes each expected result from the configuration words.

// File: rtl/sdwin_pkg.sv
package sdwin_pkg;
  localparam int ADDR_W    = 32;
  localparam int CFG_W     = 32;
  localparam int BASE_LSB  = 23;
  localparam int BASE_W    = CFG_W - BASE_LSB;
  localparam int CODE_LSB  = 17;
  localparam int CODE_W    = 3;
  localparam int EN_BIT    = 0;
  localparam int UNIT_LOG2 = 22;
  localparam logic [CODE_W-1:0] CODE_BAD = '1;
  localparam int WIDE_W    = ADDR_W + 1;
endpackage

// File: rtl/sdwin_bank_match.sv
module sdwin_bank_match
  import sdwin_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg,
  input  logic              ctrl_en,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] offset
);
  logic [WIDE_W-1:0] base_w;
  logic [WIDE_W-1:0] size_w;
  logic [WIDE_W-1:0] diff_w;
  logic [CODE_W-1:0] code;
  logic              at_or_above;

  always_comb begin
    code   = cfg[CODE_LSB +: CODE_W];
    base_w = {1'b0, cfg[CFG_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
    if (code == CODE_BAD) size_w = '0;
    else                  size_w = WIDE_W'(1) << (UNIT_LOG2 + int'(code));
    diff_w      = {1'b0, addr} - base_w;
    at_or_above = ({1'b0, addr} >= base_w);
    hit    = ctrl_en && cfg[EN_BIT] && at_or_above && (diff_w < size_w);
    offset = diff_w[ADDR_W-1:0];
  end
endmodule

// File: rtl/sdwin_prio.sv
module sdwin_prio
  import sdwin_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_BANKS-1:0]        hits,
  input  logic [NUM_BANKS*ADDR_W-1:0] offsets,
  output logic [NUM_BANKS-1:0]        grant,
  output logic [IDX_W-1:0]            idx,
  output logic [ADDR_W-1:0]           offset,
  output logic                        miss
);
  always_comb begin
    grant  = '0;
    idx    = '0;
    offset = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hits[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        idx      = IDX_W'(i);
        offset   = offsets[i*ADDR_W +: ADDR_W];
      end
    end
    miss = (hits == '0);
  end
endmodule

// File: rtl/sdwin_out_stage.sv
module sdwin_out_stage #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG_OUT) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          d_q <= '0;
        end else if (!v_q || out_ready) begin
          v_q <= in_valid;
          if (in_valid) d_q <= in_data;
        end
      end
      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;
    end else begin : g_comb
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/sdwin_decoder.sv
module sdwin_decoder
  import sdwin_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter bit REG_OUT   = 1'b1,
  parameter int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctrl_en,
  input  logic [NUM_BANKS*CFG_W-1:0] bank_cfg,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [ADDR_W-1:0]          in_addr,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [NUM_BANKS-1:0]       out_hit,
  output logic [IDX_W-1:0]           out_idx,
  output logic [ADDR_W-1:0]          out_offset,
  output logic                       out_miss
);
  localparam int RES_W = NUM_BANKS + IDX_W + ADDR_W + 1;

  logic [NUM_BANKS-1:0]        bank_hit;
  logic [NUM_BANKS*ADDR_W-1:0] bank_off;
  logic [NUM_BANKS-1:0]        sel_grant;
  logic [IDX_W-1:0]            sel_idx;
  logic [ADDR_W-1:0]           sel_off;
  logic                        sel_miss;
  logic [RES_W-1:0]            res_d;
  logic [RES_W-1:0]            res_q;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      sdwin_bank_match u_match (
        .cfg    (bank_cfg[b*CFG_W +: CFG_W]),
        .ctrl_en(ctrl_en),
        .addr   (in_addr),
        .hit    (bank_hit[b]),
        .offset (bank_off[b*ADDR_W +: ADDR_W])
      );
    end
  endgenerate

  sdwin_prio #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_prio (
    .hits   (bank_hit),
    .offsets(bank_off),
    .grant  (sel_grant),
    .idx    (sel_idx),
    .offset (sel_off),
    .miss   (sel_miss)
  );

  assign res_d = {sel_grant, sel_idx, sel_off, sel_miss};

  sdwin_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (res_d),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (res_q)
  );

  assign {out_hit, out_idx, out_offset, out_miss} = res_q;
endmodule

// File: rtl/sdwin_decoder_chk.sv
module sdwin_decoder_chk #(
  parameter int NUM_BANKS = 4,
  parameter bit REG_OUT   = 1'b1,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ctrl_en,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [NUM_BANKS-1:0] out_hit,
  input logic [IDX_W-1:0]     out_idx,
  input logic [31:0]          out_offset,
  input logic                 out_miss
);
  logic en_q;
  logic en_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else if (in_valid && in_ready) en_q <= ctrl_en;
  end
  assign en_seen = REG_OUT ? en_q : ctrl_en;

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_hit));
  assert_miss_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_miss == (out_hit == '0)));
  assert_idx_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_miss) |-> out_hit[out_idx]);
  assert_miss_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_idx == '0 && out_offset == '0));
  assert_global_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !en_seen) |-> out_miss);

  generate
    if (REG_OUT) begin : g_reg_chk
      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) &&
          $stable(out_idx) && $stable(out_offset) && $stable(out_miss)));
      assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      assert_reset_R9: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
    end
  endgenerate
endmodule

bind sdwin_decoder sdwin_decoder_chk #(
  .NUM_BANKS(NUM_BANKS), .REG_OUT(REG_OUT), .IDX_W(IDX_W)
) chk (
  .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .in_valid(in_valid),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_hit(out_hit), .out_idx(out_idx), .out_offset(out_offset),
  .out_miss(out_miss)
);

// File: tb/sdwin_decoder_test.sv
module sdwin_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_en = 1'b0;
  logic [31:0] cfg [4];
  logic [127:0] bank_cfg;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  out_hit;
  logic [1:0]  out_idx;
  logic [31:0] out_offset;
  logic        out_miss;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  string cur_req = "R9";
  logic [38:0] exp_q [$];

  always #2 clk = ~clk;
  assign bank_cfg = {cfg[3], cfg[2], cfg[1], cfg[0]};

  sdwin_decoder uut (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .bank_cfg(bank_cfg),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
    .out_idx(out_idx), .out_offset(out_offset), .out_miss(out_miss)
  );

  function automatic logic [31:0] mk(input logic [31:0] base, input int code, input bit en);
    return {base[31:23], 3'b000, 3'(code), 16'h0000, en};
  endfunction

  function automatic logic [38:0] ref_dec(input logic [31:0] a);
    for (int i = 0; i < 4; i++) begin
      longint b = longint'(cfg[i][31:23]) * 64'd8388608;
      int c = int'(cfg[i][19:17]);
      longint sz = longint'(4194304) << c;
      longint aa = longint'(a);
      if (c != 7 && ctrl_en && cfg[i][0] && aa >= b && aa < b + sz)
        return {4'(1 << i), 2'(i), 32'(aa - b), 1'b0};
    end
    return {4'b0, 2'b0, 32'b0, 1'b1};
  endfunction

  task automatic check_out();
    logic [38:0] act;
    act = {out_hit, out_idx, out_offset, out_miss};
    checks++;
    if (out_valid !== (exp_q.size() != 0)) begin
      fails++;
      $display("FAIL %s out_valid actual %0b expected %0b", cur_req, out_valid, exp_q.size() != 0);
    end else if (out_valid && act !== exp_q[0]) begin
      fails++;
      $display("FAIL %s result actual %h expected %h", cur_req, act, exp_q[0]);
    end
  endtask

  task automatic cyc(input logic v, input logic [31:0] a, input logic r);
    @(negedge clk);
    check_out();
    in_valid = v; in_addr = a; out_ready = r;
    #1;
    if (out_valid && out_ready) void'(exp_q.pop_front());
    if (in_valid && in_ready) exp_q.push_back(ref_dec(a));
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input logic [31:0] a);
    cyc(1'b1, a, 1'b1);
  endtask

  task automatic drain();
    cyc(1'b0, 32'h0, 1'b1);
    cyc(1'b0, 32'h0, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    cfg[0] = mk(32'h0000_0000, 2, 1'b1);
    cfg[1] = mk(32'h0100_0000, 0, 1'b1);
    cfg[2] = mk(32'h1000_0000, 6, 1'b1);
    cfg[3] = mk(32'hFF80_0000, 1, 1'b1);
    repeat (3) begin
      @(negedge clk);
      cur_req = "R9";
      checks++;
      if (out_valid !== 1'b0) begin
        fails++;
        $display("FAIL R9 reset out_valid actual %0b expected 0", out_valid);
      end
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    cur_req = "R9";
    cyc(1'b0, 32'h0, 1'b1);
    ctrl_en = 1'b1;

    cur_req = "R1";
    issue(32'h0000_0000); issue(32'h0FFF_FFFF); issue(32'h0FFF_0000);
    cur_req = "R2";
    issue(32'h00FF_FFFF); issue(32'h0100_0000); issue(32'h013F_FFFF);
    issue(32'h0140_0000); issue(32'h1FFF_FFFF); issue(32'h2000_0000);
    issue(32'hFF7F_FFFF); issue(32'hFF80_0000); issue(32'hFFFF_FFFF);
    cur_req = "R6";
    issue(32'h1234_5678); issue(32'hFFC0_0004);
    drain();

    cur_req = "R3";
    cfg[1] = mk(32'h0100_0000, 7, 1'b1);
    issue(32'h0100_0000); issue(32'h0100_0004);
    drain();

    cur_req = "R4";
    cfg[1] = mk(32'h0100_0000, 0, 1'b1);
    cfg[2] = mk(32'h1000_0000, 6, 1'b0);
    issue(32'h1800_0000); issue(32'h0100_0010);
    ctrl_en = 1'b0;
    issue(32'h0000_0100); issue(32'h0100_0010); issue(32'hFFFF_FFFF);
    ctrl_en = 1'b1;
    issue(32'h0000_0100);
    drain();

    cur_req = "R5";
    cfg[0] = mk(32'h0000_0000, 6, 1'b1);
    cfg[2] = mk(32'h0080_0000, 3, 1'b1);
    issue(32'h0100_0000); issue(32'h0090_0000); issue(32'h1000_0000);
    cfg[0] = mk(32'h0000_0000, 6, 1'b0);
    issue(32'h0100_0000); issue(32'h0090_0000);
    drain();

    cur_req = "R10";
    cyc(1'b1, 32'h0100_0008, 1'b0);
    ctrl_en = 1'b0;
    cyc(1'b0, 32'h0, 1'b0);
    cfg[1] = mk(32'h0100_0000, 7, 1'b0);
    cyc(1'b0, 32'h0, 1'b0);
    cyc(1'b0, 32'h0, 1'b1);
    ctrl_en = 1'b1;
    cfg[1] = mk(32'h0100_0000, 0, 1'b1);
    drain();

    cur_req = "R8";
    cfg[0] = mk(32'h0000_0000, 2, 1'b1);
    for (int k = 0; k < 400; k++) begin
      logic [31:0] a;
      case ($urandom_range(0, 5))
        0: a = 32'h0100_0000 + 32'($urandom_range(0, 3)) - 32'd1;
        1: a = 32'h0140_0000 + 32'($urandom_range(0, 3)) - 32'd1;
        2: a = 32'h0080_0000 + 32'($urandom_range(0, 3)) - 32'd1;
        3: a = 32'hFF80_0000 + 32'($urandom_range(0, 3)) - 32'd1;
        4: a = 32'hFFFF_FFFF - 32'($urandom_range(0, 3));
        default: a = $urandom;
      endcase
      if (k % 50 == 0) ctrl_en = ~ctrl_en;
      cyc(1'($urandom_range(0, 1)), a, 1'($urandom_range(0, 3) != 0));
    end
    drain();
    finish_run();
  end
endmodule